// File: doc/BRIEF.md
# CAN Interrupt Flag Register

This block holds the interrupt request flags of a CAN controller. Two flags are latched warnings. One is raised when the receive error count climbs to the warning level while the controller is still on the bus. The other is raised when the transmit error count climbs to that level. Software clears either warning by writing a one to its position.

The other two flags are live summaries over the mailboxes. One reports that some unmasked mailbox holds a remote request. The other reports that some unmasked mailbox holds a received data frame. Neither can be written, and each falls by itself once its pending bits or the mailbox mask allow it.

A per-flag enable vector selects which flags drive the single active-high interrupt line. The error counters, the mailbox storage and the protocol engine sit outside this block.

Top module: `can_irq_flags`

Flag layout (bit positions, `flags` and `wr_data`): bit 4 = receive warning, bit 3 = transmit warning, bit 2 = remote-request summary, bit 1 = data-frame summary. Every other bit is unused.

## Requirements
- R1: After reset both warning flags (bits 4 and 3) read 0, and with all inputs at 0 the whole register and `irq` read 0.
- R2: Bit 4 is set on the first clock edge where the condition (`rec` >= 96 and `bus_off` = 0) is true after having been false, including a condition that becomes true because `bus_off` falls. A `rec` of 95, or any value while `bus_off` = 1, does not set it.
- R3: Bit 3 is set on the first clock edge where `tec` >= 96 is true after having been false, whatever the value of `bus_off`. A `tec` of 95 does not set it.
- R4: A clock edge with `wr_en` = 1 and `wr_data` bit 4 (or bit 3) = 1 clears that warning flag. A 0 in that bit position, or `wr_en` = 0, leaves the flag unchanged.
- R5: When a warning's set condition and its write-1 clear fall on the same edge, the flag ends up set.
- R6: A warning flag cleared by software while its condition stays true remains 0 until the condition goes false and then true again.
- R7: Bit 2 equals the OR over all mailboxes of (`rmt_pend`[i] AND NOT `mb_mask`[i]), updated without a clock edge.
- R8: Bit 1 equals the OR over all mailboxes of (`rx_pend`[i] AND NOT `mb_mask`[i]), updated without a clock edge. With every mask bit set, bits 2 and 1 both read 0.
- R9: Writes have no effect on bits 2 and 1. Bit 0 and bits 15 to 5 always read 0.
- R10: `irq` is 1 exactly when some bit of `flags` AND `irq_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rec | input | CNT_W | Receive error count |
| tec | input | CNT_W | Transmit error count |
| bus_off | input | 1 | Controller is in the bus-off state |
| rx_pend | input | NUM_MB | Per-mailbox data frame pending |
| rmt_pend | input | NUM_MB | Per-mailbox remote request pending |
| mb_mask | input | NUM_MB | Per-mailbox interrupt mask, 1 = masked |
| wr_en | input | 1 | Flag register write strobe |
| wr_data | input | 16 | Write data, 1 clears a warning bit |
| irq_en | input | 16 | Per-flag interrupt enable |
| flags | output | 16 | Flag register read value |
| irq | output | 1 | Combined interrupt request |

## Verification
The case that is hardest to reach from the ports is a warning whose set edge lands on the same clock as a software clear. The case next to it is a clear while the condition persists, which must not re-arm. To reach the first, the stimulus drops the counter below 96 for one cycle. It then raises the counter on exactly the cycle that carries the write-1. The receive warning is also driven to its threshold while `bus_off` is high, so that it rises only when `bus_off` falls. Random counter values held near the 95/96 boundary, together with random writes, masks and pending vectors, then hit these same coincidences many more times.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
    localparam int FLAG_W  = 16;
    localparam int BIT_RXW = 4;
    localparam int BIT_TXW = 3;
    localparam int BIT_RMT = 2;
    localparam int BIT_DAT = 1;

    localparam logic [FLAG_W-1:0] DEF_MASK =
        (FLAG_W'(1) << BIT_RXW) | (FLAG_W'(1) << BIT_TXW) |
        (FLAG_W'(1) << BIT_RMT) | (FLAG_W'(1) << BIT_DAT);

    typedef struct packed {
        logic flag;
        logic cond;
    } warn_st_t;
endpackage

// File: rtl/can_warn_flag.sv
module can_warn_flag
    import can_irq_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int LIMIT    = 96,
    parameter bit USE_QUAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic             block,
    input  logic             clr,
    output logic             flag
);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(LIMIT);

    logic     over;
    logic     cond;
    logic     arm;
    warn_st_t st_d, st_q;

    assign over = (count >= LIM);

    generate
        if (USE_QUAL) begin : g_qual
            assign cond = over && !block;
        end else begin : g_plain
            assign cond = over;
        end
    endgenerate

    assign arm = cond && !st_q.cond;

    always_comb begin
        st_d      = st_q;
        st_d.cond = cond;
        if (arm) begin
            st_d.flag = 1'b1;
        end else if (clr) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;

    // R2 / R3: a fresh condition sets the flag
    a_r2_set_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (cond && !st_q.cond) |=> flag);
    // R4: write-1 clears when no set competes
    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !(cond && !st_q.cond)) |=> !flag);
    // R4: without a clear the flag holds
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);
    // R6: a persisting condition does not re-raise a cleared flag
    a_r6_no_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && st_q.cond && cond) |=> !flag);
endmodule

// File: rtl/can_pend_reduce.sv
module can_pend_reduce #(
    parameter int NUM_MB = 32,
    parameter int LANE_W = 8
) (
    input  logic [NUM_MB-1:0] pend,
    input  logic [NUM_MB-1:0] mask,
    output logic              any
);
    localparam int NLANE = (NUM_MB + LANE_W - 1) / LANE_W;
    localparam int PAD_W = NLANE * LANE_W;

    logic [PAD_W-1:0] live_pad;
    logic [NLANE-1:0] lane_any;

    always_comb begin
        live_pad             = '0;
        live_pad[NUM_MB-1:0] = pend & ~mask;
    end

    generate
        for (genvar i = 0; i < NLANE; i++) begin : g_lane
            assign lane_any[i] = |live_pad[i*LANE_W +: LANE_W];
        end
    endgenerate

    assign any = |lane_any;
endmodule

// File: rtl/can_irq_flags.sv
module can_irq_flags
    import can_irq_pkg::*;
#(
    parameter int NUM_MB = 32,
    parameter int CNT_W  = 8,
    parameter int LIMIT  = 96,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  rec,
    input  logic [CNT_W-1:0]  tec,
    input  logic              bus_off,
    input  logic [NUM_MB-1:0] rx_pend,
    input  logic [NUM_MB-1:0] rmt_pend,
    input  logic [NUM_MB-1:0] mb_mask,
    input  logic              wr_en,
    input  logic [FLAG_W-1:0] wr_data,
    input  logic [FLAG_W-1:0] irq_en,
    output logic [FLAG_W-1:0] flags,
    output logic              irq
);
    localparam int NWARN = 2;
    localparam int NSUM  = 2;

    logic [CNT_W-1:0]  warn_cnt [NWARN];
    logic [NWARN-1:0]  warn_clr;
    logic [NWARN-1:0]  warn_flag;
    logic [NUM_MB-1:0] sum_pend [NSUM];
    logic [NSUM-1:0]   sum_any;

    // index 0 = receive warning, 1 = transmit warning
    assign warn_cnt[0] = rec;
    assign warn_cnt[1] = tec;
    assign warn_clr[0] = wr_en && wr_data[BIT_RXW];
    assign warn_clr[1] = wr_en && wr_data[BIT_TXW];

    generate
        for (genvar g = 0; g < NWARN; g++) begin : g_warn
            can_warn_flag #(
                .CNT_W   (CNT_W),
                .LIMIT   (LIMIT),
                .USE_QUAL(g == 0)
            ) u_warn (
                .clk  (clk),
                .rst_n(rst_n),
                .count(warn_cnt[g]),
                .block(bus_off),
                .clr  (warn_clr[g]),
                .flag (warn_flag[g])
            );
        end
    endgenerate

    // index 0 = remote requests, 1 = data frames
    assign sum_pend[0] = rmt_pend;
    assign sum_pend[1] = rx_pend;

    generate
        for (genvar s = 0; s < NSUM; s++) begin : g_sum
            can_pend_reduce #(
                .NUM_MB(NUM_MB),
                .LANE_W(LANE_W)
            ) u_sum (
                .pend(sum_pend[s]),
                .mask(mb_mask),
                .any (sum_any[s])
            );
        end
    endgenerate

    always_comb begin
        flags          = '0;
        flags[BIT_RXW] = warn_flag[0];
        flags[BIT_TXW] = warn_flag[1];
        flags[BIT_RMT] = sum_any[0];
        flags[BIT_DAT] = sum_any[1];
    end

    assign irq = |(flags & irq_en);

    // R9: unused positions never read as 1
    a_r9_undef_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (flags & ~DEF_MASK) == '0);
    // R8: a fully masked mailbox set raises no summary flag
    a_r8_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (&mb_mask) |-> (!flags[BIT_RMT] && !flags[BIT_DAT]));
    // R10: no enables, no interrupt
    a_r10_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == '0) |-> !irq);
    // R3: transmit warning rises even while bus-off
    a_r3_tx_busoff: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_off && tec >= CNT_W'(LIMIT) && $past(tec) < CNT_W'(LIMIT)) |=> flags[BIT_TXW]);
endmodule

// File: tb/can_irq_flags_test.sv
`timescale 1ns/1ps
module can_irq_flags_test;
    localparam int NMB = 32;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [7:0]     rec = '0, tec = '0;
    logic           bus_off = 1'b0;
    logic [NMB-1:0] rx_pend = '0, rmt_pend = '0, mb_mask = '0;
    logic           wr_en = 1'b0;
    logic [15:0]    wr_data = '0, irq_en = '0;
    logic [15:0]    flags;
    logic           irq;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;

    logic m_rx = 0, m_tx = 0, p_rx = 0, p_tx = 0;

    always #2 clk = ~clk;

    can_irq_flags uut (
        .clk(clk), .rst_n(rst_n), .rec(rec), .tec(tec), .bus_off(bus_off),
        .rx_pend(rx_pend), .rmt_pend(rmt_pend), .mb_mask(mb_mask),
        .wr_en(wr_en), .wr_data(wr_data), .irq_en(irq_en),
        .flags(flags), .irq(irq)
    );

    function automatic logic [15:0] exp_flags();
        logic [15:0] e = '0;
        e[4] = m_rx;
        e[3] = m_tx;
        e[2] = |(rmt_pend & ~mb_mask);
        e[1] = |(rx_pend & ~mb_mask);
        return e;
    endfunction

    task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input string tag, input logic [7:0] r, input logic [7:0] t,
                        input logic bo, input logic [NMB-1:0] dp, input logic [NMB-1:0] rp,
                        input logic [NMB-1:0] mk, input logic we, input logic [15:0] wd,
                        input logic [15:0] en);
        logic cr, ct;
        @(negedge clk);
        rec = r; tec = t; bus_off = bo; rx_pend = dp; rmt_pend = rp;
        mb_mask = mk; wr_en = we; wr_data = wd; irq_en = en;
        @(posedge clk);
        cr = (r >= 8'd96) && !bo;
        ct = (t >= 8'd96);
        m_rx = (cr && !p_rx) ? 1'b1 : ((we && wd[4]) ? 1'b0 : m_rx);
        m_tx = (ct && !p_tx) ? 1'b1 : ((we && wd[3]) ? 1'b0 : m_tx);
        p_rx = cr;
        p_tx = ct;
        #1;
        check16({tag, " flags"}, flags, exp_flags());
        check16({tag, " R10 irq"}, {15'b0, irq}, {15'b0, |(exp_flags() & en)});
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        #1;
        check16("R1 reset flags", flags, 16'h0);
        check16("R1 reset irq", {15'b0, irq}, 16'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 receive threshold boundary and bus-off qualification
        step("R2 rec95", 8'd95, 0, 0, '0, '0, '0, 0, '0, 16'hFFFF);
        step("R2 rec96", 8'd96, 0, 0, '0, '0, '0, 0, '0, 16'hFFFF);
        step("R4 clr rx", 8'd10, 0, 0, '0, '0, '0, 1, 16'h0010, 16'hFFFF);
        step("R2 busoff", 8'd200, 0, 1, '0, '0, '0, 0, '0, 16'hFFFF);
        step("R2 busoff hold", 8'd200, 0, 1, '0, '0, '0, 0, '0, 16'hFFFF);
        step("R2 busoff drop", 8'd200, 0, 0, '0, '0, '0, 0, '0, 16'hFFFF);
        // R3 transmit threshold ignores bus-off
        step("R3 tec95", 8'd200, 8'd95, 1, '0, '0, '0, 0, '0, 16'hFFFF);
        step("R3 tec96", 8'd200, 8'd96, 1, '0, '0, '0, 0, '0, 16'hFFFF);
        // R4 write zero keeps, write one clears
        step("R4 wr0", 8'd200, 8'd96, 0, '0, '0, '0, 1, 16'h0000, 16'hFFFF);
        step("R4 wr_en0", 8'd200, 8'd96, 0, '0, '0, '0, 0, 16'h0018, 16'hFFFF);
        step("R6 clr held", 8'd200, 8'd96, 0, '0, '0, '0, 1, 16'h0018, 16'hFFFF);
        step("R6 no rearm", 8'd200, 8'd96, 0, '0, '0, '0, 0, '0, 16'hFFFF);
        // R5 set beats clear
        step("R5 drop", 8'd0, 8'd0, 0, '0, '0, '0, 0, '0, 16'hFFFF);
        step("R5 set+clr", 8'd97, 8'd97, 0, '0, '0, '0, 1, 16'h0018, 16'hFFFF);
        // R7 R8 R9 summaries
        step("R7 rmt31", 0, 0, 0, '0, 32'h8000_0000, '0, 1, 16'h0018, 16'h0004);
        step("R8 dat0", 0, 0, 0, 32'h1, '0, '0, 0, '0, 16'h0002);
        step("R8 allmask", 0, 0, 0, '1, '1, '1, 0, '0, 16'hFFFF);
        step("R9 wr summ", 0, 0, 0, '1, '1, '0, 1, 16'hFFE7, 16'hFFFF);
        step("R7 partmask", 0, 0, 0, 32'h0F, 32'hF0, 32'h0F, 0, '0, 16'h0006);
        step("R10 en off", 0, 0, 0, '1, '1, '0, 0, '0, 16'h0000);

        for (int i = 0; i < 3000; i++) begin
            logic [7:0] r, t;
            r = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'($urandom_range(93, 99));
            t = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'($urandom_range(93, 99));
            step("R2 R3 R4 R5 R6 R7 R8 R9 random", r, t, ($urandom_range(0, 3) == 0),
                 NMB'($urandom & $urandom & $urandom), NMB'($urandom & $urandom & $urandom),
                 NMB'($urandom | $urandom), ($urandom_range(0, 2) == 0),
                 16'($urandom), 16'($urandom));
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule